// File: doc/BRIEF.md
# Bridge PWM Generator with Dead Band

This block produces a pulse-width-modulated waveform on four switch outputs, A to D. Those outputs can drive one switch, a complementary half bridge or a full bridge. A free-running period counter is compared against a duty value. A mode input then chooses how the modulated level is steered onto the outputs:

- **Single mode:** only output A switches.
- **Dual mode:** B is driven as the complement of A. Each turn-on is held back by a programmable dead band, so one switch of the half bridge is off before its partner conducts.
- **Quad modes:** one diagonal switch of a full bridge is held on and its partner is modulated. The forward or reverse choice selects which diagonal pair is used.

Each output has a selectable active level. Period, duty and mode are taken only at a period boundary, so a reconfiguration never produces a truncated or stretched pulse. When the bridge direction is reversed, all four switches are held off for one full period before the new pair is enabled.

Top module: `bridge_pwm`

## Requirements
- R1: The period counter runs from 0 to P-1 and restarts, where P is the latched period value. A period value of 0 or 1 gives a cycle length of one clock, so the modulated level repeats every max(P,1) clocks.
- R2: The modulated level is active while the counter is below the latched duty value D. D = 0 keeps it inactive for the whole period, and D >= P keeps it active for the whole period.
- R3: In single mode (mode code 2'b00), only A (out_o[0]) carries the modulated level. B, C and D (out_o[1], out_o[2], out_o[3]) stay inactive.
- R4: In dual mode (mode code 2'b01), B follows the complement of A. With a dead-band field value F, every turn-on of A or B is delayed by F*4 clocks. Per period, A is therefore active max(0, min(D,P)-4F) clocks and B is active max(0, P-min(D,P)-4F) clocks. When 0 < D < P, C and D stay inactive. When D = 0, B is active the whole period. When D >= P, A is active the whole period.
- R5: In dual mode with a nonzero dead band, after each change of the modulated level both A and B are inactive for exactly F*4 consecutive clocks, provided the following phase lasts longer than that.
- R6: In dual mode, A and B are never active in the same clock. A phase shorter than or equal to the dead band leaves its output inactive for that phase.
- R7: In quad forward mode (mode code 2'b10), A is held active, D carries the modulated level, and B and C are inactive. In quad reverse mode (2'b11), C is held active, B carries the modulated level, and A and D are inactive.
- R8: Switching between quad forward and quad reverse forces all four outputs inactive for exactly one full period before the new pair is enabled. Entering a quad mode from single or dual mode does not force this idle period.
- R9: Period, duty and mode are latched only at the period boundary. A change in mid-period leaves the current period's pulse lengths unchanged.
- R10: An output drives its polarity bit when active and the inverse of that bit when inactive.
  - In single and dual mode, output n uses pol_i[n].
  - In quad modes, A and C use pol_i[0], and B and D use pol_i[1].
- R11: While rst_n is low, all outputs are inactive and the mode is single.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CNT_W | Period value P, latched at a period boundary |
| duty_i | input | CNT_W | Duty value D, latched at a period boundary |
| mode_i | input | 2 | 00 single, 01 dual, 10 quad forward, 11 quad reverse |
| deadband_i | input | DB_W | Dead-band field F; delay is F*DB_STEP clocks (dual mode only) |
| pol_i | input | 4 | Active level per output (quad modes use bits 1:0 per pair) |
| out_o | output | 4 | Switch drives, bit 0 = A … bit 3 = D |

## Verification
The functions most likely to collide are the period-boundary latch and a reconfiguration written in the middle of a period.

- **Duty and period change:** the bench detects the first active clock of a pulse, which places it just after a boundary, and writes a new duty and period in that clock. It then measures four successive run lengths. The first two must follow the old settings and the next two the new ones.
- **Direction change:** the bench reverses a running full bridge at an arbitrary clock. It checks that the single all-off run that follows lasts exactly one period.
- **Dead band at the duty limits:** sweeps push the dead band against phases of every length, including duty 0 and duty at or above the period. Per-period active counts are judged against the closed-form values in R4.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_FWD    = 2'b10,
    MODE_REV    = 2'b11
  } pwm_mode_e;

  // Both quad variants share the upper code bit.
  function automatic logic is_quad(pwm_mode_e m);
    return m[1];
  endfunction

  // A reversal of the full bridge: quad to the other quad.
  function automatic logic dir_flip(pwm_mode_e old_m, pwm_mode_e new_m);
    return is_quad(old_m) && is_quad(new_m) && (old_m != new_m);
  endfunction

  // Pin level from an active flag and an active-level bit.
  function automatic logic drive_level(logic act, logic pol);
    return act ~^ pol;
  endfunction

endpackage

// File: rtl/bpwm_timebase.sv
module bpwm_timebase
  import bpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [1:0]       mode_i,
  output logic             raw_o,
  output pwm_mode_e        mode_o,
  output logic             blank_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] duty_q;
  pwm_mode_e        mode_q;
  logic             blank_q;
  logic [CNT_W:0]   cnt_nx;
  logic             wrap;
  pwm_mode_e        mode_in;

  assign mode_in = pwm_mode_e'(mode_i);
  assign cnt_nx  = {1'b0, cnt_q} + (CNT_W+1)'(1);
  // Boundary when the next count would reach the period (P of 0 or 1 -> every clock).
  assign wrap    = cnt_nx >= {1'b0, per_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      mode_q  <= MODE_SINGLE;
      blank_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      per_q   <= period_i;
      duty_q  <= duty_i;
      mode_q  <= mode_in;
      blank_q <= dir_flip(mode_q, mode_in);
    end else begin
      cnt_q   <= cnt_nx[CNT_W-1:0];
    end
  end

  assign raw_o   = cnt_q < duty_q;
  assign mode_o  = mode_q;
  assign blank_o = blank_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || (cnt_q < per_q));

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(duty_q) && $stable(per_q) && $stable(mode_q)));

  // R8
  blank_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_q && !wrap) |=> blank_q);

endmodule

// File: rtl/bpwm_deadband.sv
module bpwm_deadband #(
  parameter int DB_W    = 4,
  parameter int DB_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_i,
  input  logic [DB_W-1:0] db_i,
  output logic            raw_d_o,
  output logic            a_on_o,
  output logic            b_on_o
);

  localparam int DZ_MAX = ((1 << DB_W) - 1) * DB_STEP;
  localparam int SC_W   = $clog2(DZ_MAX + 2);

  logic            raw_d;
  logic [SC_W-1:0] sc_q;
  logic [SC_W-1:0] dz;
  logic            hold_ok;

  function automatic logic [SC_W-1:0] dz_of(logic [DB_W-1:0] f);
    return SC_W'(f) * SC_W'(DB_STEP);
  endfunction

  assign dz = dz_of(db_i);

  // sc_q counts clocks since the modulated level last changed, saturating.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_d <= 1'b0;
      sc_q  <= '0;
    end else begin
      raw_d <= raw_i;
      if (raw_i != raw_d)  sc_q <= '0;
      else if (sc_q != '1) sc_q <= sc_q + SC_W'(1);
    end
  end

  assign hold_ok = sc_q >= dz;
  assign raw_d_o = raw_d;
  assign a_on_o  = raw_d && hold_ok;
  assign b_on_o  = !raw_d && hold_ok;

  // R5
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dz != '0) && (raw_d != $past(raw_d))) |-> (!a_on_o && !b_on_o));

  // R6
  pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_on_o && b_on_o));

endmodule

// File: rtl/bpwm_steer.sv
module bpwm_steer
  import bpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_d_i,
  input  logic       a_on_i,
  input  logic       b_on_i,
  input  pwm_mode_e  mode_i,
  input  logic       blank_i,
  input  logic [3:0] pol_i,
  output logic [3:0] out_o
);

  pwm_mode_e  mode_d;
  logic       blank_d;
  logic [3:0] act;
  logic [3:0] lvl;

  // Align mode and idle flag with the delayed modulated level.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_d  <= MODE_SINGLE;
      blank_d <= 1'b0;
    end else begin
      mode_d  <= mode_i;
      blank_d <= blank_i;
    end
  end

  always_comb begin
    act = 4'b0000;
    unique case (mode_d)
      MODE_SINGLE: act = {3'b000, raw_d_i};
      MODE_DUAL:   act = {2'b00, b_on_i, a_on_i};
      MODE_FWD:    act = {raw_d_i, 2'b00, 1'b1};
      MODE_REV:    act = {1'b0, 1'b1, raw_d_i, 1'b0};
      default:     act = 4'b0000;
    endcase
    if (blank_d) act = 4'b0000;
  end

  assign lvl = is_quad(mode_d) ? {pol_i[1], pol_i[0], pol_i[1], pol_i[0]} : pol_i;

  for (genvar g = 0; g < 4; g++) begin : g_pin
    assign out_o[g] = drive_level(act[g], lvl[g]);
  end

  // R6
  dual_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_d == MODE_DUAL) |-> !(act[0] && act[1]));

  // R7
  quad_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_d == MODE_FWD) |-> (!act[1] && !act[2] && (act[0] == !blank_d)));

  // R8
  blank_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_flip($past(mode_d), mode_d) |-> blank_d);

  // R3
  single_only_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_d == MODE_SINGLE) |-> (act[3:1] == 3'b000));

endmodule

// File: rtl/bridge_pwm.sv
module bridge_pwm
  import bpwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DB_W    = 4,
  parameter int DB_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [1:0]       mode_i,
  input  logic [DB_W-1:0]  deadband_i,
  input  logic [3:0]       pol_i,
  output logic [3:0]       out_o
);

  logic      raw;
  logic      raw_d;
  logic      a_on;
  logic      b_on;
  logic      blank;
  pwm_mode_e mode_q;

  bpwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .duty_i   (duty_i),
    .mode_i   (mode_i),
    .raw_o    (raw),
    .mode_o   (mode_q),
    .blank_o  (blank)
  );

  bpwm_deadband #(.DB_W(DB_W), .DB_STEP(DB_STEP)) u_db (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (raw),
    .db_i    (deadband_i),
    .raw_d_o (raw_d),
    .a_on_o  (a_on),
    .b_on_o  (b_on)
  );

  bpwm_steer u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_d_i (raw_d),
    .a_on_i  (a_on),
    .b_on_i  (b_on),
    .mode_i  (mode_q),
    .blank_i (blank),
    .pol_i   (pol_i),
    .out_o   (out_o)
  );

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (out_o == ~pol_i));

endmodule

// File: tb/tb_bridge_pwm.sv
module tb_bridge_pwm;
  localparam int CW = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] period_i = '0;
  logic [CW-1:0] duty_i = '0;
  logic [1:0]    mode_i = 2'b00;
  logic [DW-1:0] deadband_i = '0;
  logic [3:0]    pol_i = 4'hF;
  logic [3:0]    out_o;

  always #4 clk = ~clk;

  bridge_pwm #(.CNT_W(CW), .DB_W(DW), .DB_STEP(4)) dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
    .mode_i(mode_i), .deadband_i(deadband_i), .pol_i(pol_i), .out_o(out_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int last_p = 1;
  bit done = 0;
  int ca [4];
  int both_cnt;

  // Active when the pin equals the level chosen by R10's mapping.
  function automatic bit act_of(int idx, logic [1:0] m, logic [3:0] pl, logic [3:0] o);
    logic lv;
    lv = m[1] ? pl[idx % 2] : pl[idx];
    return o[idx] == lv;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int clip0(int a);
    return (a < 0) ? 0 : a;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic setup(logic [1:0] m, int p, int d, int db, logic [3:0] pl);
    mode_i = m; period_i = CW'(p); duty_i = CW'(d);
    deadband_i = DW'(db); pol_i = pl;
    repeat (last_p + p + 24) @(negedge clk);
    last_p = (p == 0) ? 1 : p;
  endtask

  task automatic window(int n);
    ca = '{0, 0, 0, 0};
    both_cnt = 0;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++)
        if (act_of(i, mode_i, pol_i, out_o)) ca[i]++;
      if (act_of(0, mode_i, pol_i, out_o) && act_of(1, mode_i, pol_i, out_o)) both_cnt++;
    end
  endtask

  task automatic wait_rise_a();
    bit prev;
    prev = act_of(0, mode_i, pol_i, out_o);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (act_of(0, mode_i, pol_i, out_o) && !prev) break;
      prev = act_of(0, mode_i, pol_i, out_o);
    end
  endtask

  // Length of the run of equal A activity starting with the current sample.
  task automatic run_len(output int len);
    bit lvl0;
    lvl0 = act_of(0, mode_i, pol_i, out_o);
    len = 1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (act_of(0, mode_i, pol_i, out_o) != lvl0) break;
      len++;
    end
  endtask

  initial begin
    int pe, dc, len, run, best, c0;
    // R11: outputs inactive in reset
    repeat (5) @(negedge clk);
    chk("R11 reset outputs", int'(out_o), 0);
    rst_n = 1'b1;

    // R1: spacing between pulses equals the period
    for (int p = 2; p <= 12; p++) begin
      setup(2'b00, p, 1, 0, 4'hF);
      wait_rise_a();
      c0 = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk); c0++;
        if (act_of(0, mode_i, pol_i, out_o)) break;
      end
      chk("R1 pulse spacing", c0, p);
    end

    // R2 / R3: single-mode sweep
    for (int p = 0; p <= 12; p++)
      for (int d = 0; d <= p + 1; d++) begin
        pe = (p == 0) ? 1 : p;
        setup(2'b00, p, d, 0, 4'hF);
        window(pe);
        chk("R2 single A count", ca[0], imin(d, pe));
        chk("R3 single B/C/D idle", ca[1] + ca[2] + ca[3], 0);
      end

    // R4 / R6: dual-mode sweep over dead band
    for (int db = 0; db <= 3; db++)
      for (int p = 1; p <= 12; p++)
        for (int d = 0; d <= p + 1; d++) begin
          setup(2'b01, p, d, db, 4'hF);
          window(p);
          dc = imin(d, p);
          if (dc == p) begin
            chk("R4 dual A full", ca[0], p); chk("R4 dual B off", ca[1], 0);
          end else if (dc == 0) begin
            chk("R4 dual A off", ca[0], 0); chk("R4 dual B full", ca[1], p);
          end else begin
            chk("R4 dual A count", ca[0], clip0(dc - 4 * db));
            chk("R4 dual B count", ca[1], clip0(p - dc - 4 * db));
          end
          chk("R6 dual overlap", both_cnt, 0);
          chk("R4 dual C/D idle", ca[2] + ca[3], 0);
        end

    // R5: exact gap after A turns off
    setup(2'b01, 20, 10, 2, 4'hF);
    wait_rise_a();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!act_of(0, mode_i, pol_i, out_o)) break;
    end
    run = 0;
    for (int k = 0; k < 40; k++) begin
      if (act_of(1, mode_i, pol_i, out_o) || act_of(0, mode_i, pol_i, out_o)) break;
      run++;
      @(negedge clk);
    end
    chk("R5 dead gap", run, 8);

    // R7: quad sweeps
    for (int m = 2; m <= 3; m++)
      for (int p = 1; p <= 8; p++)
        for (int d = 0; d <= p + 1; d++) begin
          setup(2'(m), p, d, 0, 4'hF);
          window(p);
          if (m == 2) begin
            chk("R7 fwd A held", ca[0], p); chk("R7 fwd D mod", ca[3], imin(d, p));
            chk("R7 fwd B/C idle", ca[1] + ca[2], 0);
          end else begin
            chk("R7 rev C held", ca[2], p); chk("R7 rev B mod", ca[1], imin(d, p));
            chk("R7 rev A/D idle", ca[0] + ca[3], 0);
          end
        end

    // R8: direction change idles exactly one period
    setup(2'b10, 8, 3, 0, 4'hF);
    repeat (3) @(negedge clk);
    mode_i = 2'b11;
    run = 0; best = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (out_o == 4'b0000) begin run++; if (run > best) best = run; end
      else run = 0;
    end
    chk("R8 reversal idle length", best, 8);
    window(8);
    chk("R8 reverse C after idle", ca[2], 8);
    // R8: dual to quad gives no idle period
    setup(2'b01, 8, 3, 0, 4'hF);
    mode_i = 2'b10;
    run = 0; best = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (out_o == 4'b0000) begin run++; if (run > best) best = run; end
      else run = 0;
    end
    chk("R8 entry without idle", (best >= 8) ? 1 : 0, 0);
    last_p = 8;

    // R9: mid-period duty/period write takes effect at the boundary
    setup(2'b00, 10, 4, 0, 4'hF);
    wait_rise_a();
    duty_i = 8'd7; period_i = 8'd12;
    run_len(len); chk("R9 old active run", len, 4);
    run_len(len); chk("R9 old idle run", len, 6);
    run_len(len); chk("R9 new active run", len, 7);
    run_len(len); chk("R9 new idle run", len, 5);
    last_p = 12;

    // R10: per-output polarity in dual mode
    setup(2'b01, 10, 5, 1, 4'b1010);
    ca = '{0, 0, 0, 0};
    repeat (10) begin
      @(negedge clk);
      if (out_o[0] == 1'b0) ca[0]++;
      if (out_o[1] == 1'b1) ca[1]++;
      if (out_o[2] == 1'b1) ca[2]++;
      if (out_o[3] == 1'b1) ca[3]++;
    end
    chk("R10 dual A active-low", ca[0], 1);
    chk("R10 dual B active-high", ca[1], 1);
    chk("R10 idle C high", ca[2], 10);
    chk("R10 idle D low", ca[3], 0);

    // R10: per-pair polarity in quad forward
    setup(2'b10, 10, 3, 0, 4'b0001);
    ca = '{0, 0, 0, 0};
    repeat (10) begin
      @(negedge clk);
      if (out_o[0] == 1'b1) ca[0]++;
      if (out_o[1] == 1'b1) ca[1]++;
      if (out_o[2] == 1'b1) ca[2]++;
      if (out_o[3] == 1'b0) ca[3]++;
    end
    chk("R10 quad A held high", ca[0], 10);
    chk("R10 quad B idle high", ca[1], 10);
    chk("R10 quad C idle low", ca[2], 0);
    chk("R10 quad D low pulses", ca[3], 3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule